// File: doc/BRIEF.md
# SMBus Target Block-Read Engine

This block is the target side of a two-wire SMBus/I2C link. Its only job is to serve block reads out of a 256-location byte register space. A host picks where a read begins in one of two ways. The first is a generic command write, which carries a start address and a requested byte count. The second is a single reserved command byte, which selects a start address and a length that are fixed when the block is built. The engine then answers each read frame in the same way: it sends the byte count first, then sequential register bytes.

The engine keeps one base pointer, and that pointer persists between frames. Each command write loads the pointer and the count. A read frame that follows without a new command picks up from the byte after the last one sent, and it reports the same count again. When the host keeps acknowledging past the count, the engine keeps streaming bytes. When the host sends a NACK, the engine lets go of the data line. The pointer does not wrap past the top of the space; it saturates instead. Locations past the implemented range read as zero.

The engine samples both bus lines through synchronizers. It pulls the data line low through an enable, and it fetches bytes through a combinational register read port.

Top module: `smb_blkrd_target`

## Requirements
- R1: The target acknowledges only frames whose 7-bit address equals the parameter TGT_ADDR (default 2Ch). For any other address it leaves the data line released until the next START.
- R2: A generic write of F1h, 02h, start address A, and count N (01h to 20h), each byte acknowledged, makes the following read frame return N first and then the register bytes from A upward.
- R3: A single command byte from F2h to FDh is acknowledged. It selects entry k = code − F2h of the parameter tables FIX_START and FIX_LEN. The following read frame returns FIX_LEN[k] and then the bytes from FIX_START[k] upward.
- R4: The target does not acknowledge, and does not change the pointer or the count, when it receives any of the following: a command byte outside F1h to FDh, a generic second byte other than 02h, a count N of 00h or above 20h, or any byte after a complete command.
- R5: The read address advances by one after every data byte sent. Data continues past the requested count for as long as the host acknowledges.
- R6: After a host NACK, including an early one, the target keeps the data line released until the next START or STOP. A STOP always releases it.
- R7: A read frame with no new command resumes at the address just past the last data byte actually sent, and it reports the same count byte. The pointer changes only by a command load or a step of one.
- R8: Addresses above the parameter MAP_LAST (default BFh) read as 00h, and the register read port is not used for them.
- R9: Past address FFh the pointer saturates instead of wrapping. All later reads return 00h until a new command loads the pointer.
- R10: The target starts pulling the data line low only while the clock line is low.
- R11: After reset the data line is released, the pointer is 00h, and the count byte is 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_in | input | 1 | Sampled level of the bus clock line |
| bus_dat_in | input | 1 | Sampled level of the bus data line |
| bus_dat_pull | output | 1 | Pulls the data line low when 1 |
| reg_addr | output | 8 | Register read address |
| reg_rdata | input | 8 | Register read data, combinational from reg_addr |

## Verification
Some properties can be stated as rules between any two cycles, and the assertions check those on every cycle. The data line begins to be pulled only while the synchronized clock is low, and a STOP releases it. The pointer moves only by a load or a single step, and it stays saturated once it has passed the top. The stored count always lies between 1 and 20h. Everything that depends on the order of bytes in a frame can only be shown by the bench's scenarios. This covers command decoding, the count-first read order, streaming past the count, resumption across frames, zero fill above the mapped range, rejection of malformed commands, and silence toward a foreign address.

// File: rtl/smb_blkrd_pkg.sv
package smb_blkrd_pkg;
   localparam logic [7:0] CMD_GEN    = 8'hF1;
   localparam logic [7:0] CMD_FIX_LO = 8'hF2;
   localparam logic [7:0] CMD_FIX_HI = 8'hFD;
   localparam logic [7:0] GEN_LEN    = 8'h02;
   localparam logic [7:0] N_MAX      = 8'h20;
   localparam int         NUM_FIX    = int'(CMD_FIX_HI) - int'(CMD_FIX_LO) + 1;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK
   } link_st_e;

   typedef enum logic [2:0] {
      PH_CMD, PH_CNT, PH_ADR, PH_N, PH_DONE
   } frame_ph_e;
endpackage

// File: rtl/smb_bus_sense.sv
module smb_bus_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_line,
   input  logic dat_line,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic                   scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], clk_line};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], dat_line};
         scl_p  <= scl_sh[SYNC_STAGES-1];
         sda_p  <= sda_sh[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_sh[SYNC_STAGES-1];
   assign sda_s     = sda_sh[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_fixed_lut.sv
module smb_fixed_lut
   import smb_blkrd_pkg::*;
#(
   parameter logic [NUM_FIX*8-1:0] FIX_START = '0,
   parameter logic [NUM_FIX*8-1:0] FIX_LEN   = {NUM_FIX{8'h01}}
) (
   input  logic [7:0] code,
   output logic       hit,
   output logic [7:0] start,
   output logic [7:0] len
);
   for (genvar k = 0; k < NUM_FIX; k++) begin : g_len_chk
      if (FIX_LEN[k*8+:8] == 8'h00 || FIX_LEN[k*8+:8] > N_MAX) begin : g_bad_len
         $error("fixed-block length out of range 1..20h");
      end
   end

   always_comb begin
      hit   = 1'b0;
      start = '0;
      len   = '0;
      for (int k = 0; k < NUM_FIX; k++) begin
         if (code == CMD_FIX_LO + 8'(k)) begin
            hit   = 1'b1;
            start = FIX_START[k*8+:8];
            len   = FIX_LEN[k*8+:8];
         end
      end
   end
endmodule

// File: rtl/smb_ptr_unit.sv
module smb_ptr_unit #(
   parameter logic [7:0] MAP_LAST = 8'hBF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_en,
   input  logic [7:0] ld_ptr,
   input  logic [7:0] ld_cnt,
   input  logic       adv,
   input  logic [7:0] reg_rdata,
   output logic [7:0] reg_addr,
   output logic [8:0] ptr_q,
   output logic [7:0] cnt_q,
   output logic [7:0] tx_data
);
   localparam logic [8:0] PTR_SAT = 9'h100;

   logic in_map;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= 8'h01;
      end else if (ld_en) begin
         ptr_q <= {1'b0, ld_ptr};
         cnt_q <= ld_cnt;
      end else if (adv && ptr_q != PTR_SAT) begin
         ptr_q <= ptr_q + 9'd1;
      end
   end

   if (MAP_LAST == 8'hFF) begin : g_full_map
      assign in_map = ~ptr_q[8];
   end else begin : g_part_map
      assign in_map = (ptr_q <= {1'b0, MAP_LAST});
   end

   assign reg_addr = ptr_q[7:0];
   assign tx_data  = in_map ? reg_rdata : 8'h00;
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
   import smb_blkrd_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'h2C
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       lut_hit,
   input  logic [7:0] lut_start,
   input  logic [7:0] lut_len,
   input  logic [7:0] cnt_q,
   input  logic [7:0] tx_data,
   output logic [7:0] rx_byte,
   output logic       ld_en,
   output logic [7:0] ld_ptr,
   output logic [7:0] ld_cnt,
   output logic       adv,
   output logic       drive
);
   localparam logic [3:0] BITS = 4'd8;

   link_st_e   st;
   frame_ph_e  ph, ph_nxt;
   logic [3:0] bitn;
   logic [7:0] shreg, stash;
   logic       addr_done, to_tx, first, hack_ok, acc, byte_end;

   assign rx_byte  = shreg;
   assign byte_end = (st == ST_RX) && scl_fall && (bitn == BITS);

   always_comb begin
      acc    = 1'b0;
      ph_nxt = PH_DONE;
      ld_en  = 1'b0;
      ld_ptr = lut_start;
      ld_cnt = lut_len;
      if (byte_end) begin
         if (!addr_done) begin
            acc = (shreg[7:1] == TGT_ADDR);
         end else begin
            case (ph)
               PH_CMD: if (shreg == CMD_GEN) begin
                  acc = 1'b1; ph_nxt = PH_CNT;
               end else if (lut_hit) begin
                  acc = 1'b1; ld_en = 1'b1;
               end
               PH_CNT: if (shreg == GEN_LEN) begin
                  acc = 1'b1; ph_nxt = PH_ADR;
               end
               PH_ADR: begin
                  acc = 1'b1; ph_nxt = PH_N;
               end
               PH_N: if (shreg != 8'h00 && shreg <= N_MAX) begin
                  acc = 1'b1; ld_en = 1'b1; ld_ptr = stash; ld_cnt = shreg;
               end
               default: ;
            endcase
         end
      end
   end

   assign adv = (st == ST_HACK) && scl_rise && !first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_DONE;
         bitn      <= '0;
         shreg     <= '0;
         stash     <= '0;
         addr_done <= 1'b0;
         to_tx     <= 1'b0;
         first     <= 1'b0;
         hack_ok   <= 1'b0;
         drive     <= 1'b0;
      end else if (start_det) begin
         st        <= ST_RX;
         bitn      <= '0;
         addr_done <= 1'b0;
         drive     <= 1'b0;
      end else if (stop_det) begin
         st    <= ST_IDLE;
         drive <= 1'b0;
      end else begin
         case (st)
            ST_RX: begin
               if (scl_rise && bitn != BITS) begin
                  shreg <= {shreg[6:0], sda_s};
                  bitn  <= bitn + 4'd1;
               end else if (byte_end) begin
                  st    <= acc ? ST_ACK : ST_IDLE;
                  drive <= acc;
                  if (!addr_done) begin
                     addr_done <= 1'b1;
                     to_tx     <= shreg[0];
                     ph        <= PH_CMD;
                  end else begin
                     ph <= ph_nxt;
                     if (ph == PH_ADR) stash <= shreg;
                  end
               end
            end
            ST_ACK: if (scl_fall) begin
               bitn <= '0;
               if (to_tx) begin
                  shreg <= cnt_q;
                  first <= 1'b1;
                  st    <= ST_TX;
                  drive <= ~cnt_q[7];
               end else begin
                  st    <= ST_RX;
                  drive <= 1'b0;
               end
            end
            ST_TX: if (scl_fall) begin
               if (bitn == BITS - 4'd1) begin
                  st    <= ST_HACK;
                  drive <= 1'b0;
               end else begin
                  shreg <= {shreg[6:0], 1'b0};
                  bitn  <= bitn + 4'd1;
                  drive <= ~shreg[6];
               end
            end
            ST_HACK: begin
               if (scl_rise) begin
                  hack_ok <= ~sda_s;
               end else if (scl_fall) begin
                  if (hack_ok) begin
                     shreg <= tx_data;
                     first <= 1'b0;
                     bitn  <= '0;
                     st    <= ST_TX;
                     drive <= ~tx_data[7];
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/smb_blkrd_target.sv
module smb_blkrd_target
   import smb_blkrd_pkg::*;
#(
   parameter logic [6:0]           TGT_ADDR    = 7'h2C,
   parameter logic [7:0]           MAP_LAST    = 8'hBF,
   parameter int                   SYNC_STAGES = 2,
   parameter logic [NUM_FIX*8-1:0] FIX_START   = {8'hF8, 8'hE0, 8'hC0, 8'hA0, 8'h90, 8'h80,
                                                  8'h70, 8'h60, 8'h50, 8'h40, 8'h30, 8'h20},
   parameter logic [NUM_FIX*8-1:0] FIX_LEN     = {8'h08, {10{8'h04}}, 8'h06}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_clk_in,
   input  logic       bus_dat_in,
   output logic       bus_dat_pull,
   output logic [7:0] reg_addr,
   input  logic [7:0] reg_rdata
);
   logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic       lut_hit, ld_en, adv;
   logic [7:0] lut_start, lut_len, rx_byte, ld_ptr, ld_cnt, cnt_q, tx_data;
   logic [8:0] ptr_q;

   smb_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk(clk), .rst_n(rst_n), .clk_line(bus_clk_in), .dat_line(bus_dat_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   smb_fixed_lut #(.FIX_START(FIX_START), .FIX_LEN(FIX_LEN)) u_lut (
      .code(rx_byte), .hit(lut_hit), .start(lut_start), .len(lut_len));

   smb_ptr_unit #(.MAP_LAST(MAP_LAST)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_ptr(ld_ptr), .ld_cnt(ld_cnt),
      .adv(adv), .reg_rdata(reg_rdata), .reg_addr(reg_addr), .ptr_q(ptr_q),
      .cnt_q(cnt_q), .tx_data(tx_data));

   smb_link_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .lut_hit(lut_hit), .lut_start(lut_start), .lut_len(lut_len),
      .cnt_q(cnt_q), .tx_data(tx_data), .rx_byte(rx_byte), .ld_en(ld_en),
      .ld_ptr(ld_ptr), .ld_cnt(ld_cnt), .adv(adv), .drive(bus_dat_pull));
endmodule

// File: rtl/smb_blkrd_chk.sv
module smb_blkrd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic       stop_det,
   input logic [8:0] ptr_q,
   input logic       ld_en,
   input logic [7:0] cnt_q
);
   p_pull_low_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && !$past(sda_oe)) |-> !scl_s);

   p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q != $past(ptr_q)) |-> ($past(ld_en) || ptr_q == $past(ptr_q) + 9'd1));

   p_ptr_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q == 9'h100 && !ld_en) |=> (ptr_q == 9'h100));

   p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != 8'h00) && (cnt_q <= 8'h20));
endmodule

bind smb_blkrd_target smb_blkrd_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(bus_dat_pull),
   .stop_det(stop_det), .ptr_q(ptr_q), .ld_en(ld_en), .cnt_q(cnt_q));

// File: tb/smb_blkrd_target_tb.sv
module smb_blkrd_target_tb;
   localparam int         CLK_PERIOD = 10;
   localparam int         Q          = 8;
   localparam logic [6:0] TGT        = 7'h2C;
   localparam logic [7:0] MAPL       = 8'hBF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       sda_pull, sda_line;
   logic [7:0] reg_addr, reg_rdata;
   int         errors = 0, checks = 0, exp_ptr = 0, r10_bad = 0;
   logic       prev_pull = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line  = sda_m & ~sda_pull;
   assign reg_rdata = reg_addr ^ 8'h5A;

   smb_blkrd_target #(.TGT_ADDR(TGT), .MAP_LAST(MAPL)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_clk_in(scl_m), .bus_dat_in(sda_line),
      .bus_dat_pull(sda_pull), .reg_addr(reg_addr), .reg_rdata(reg_rdata));

   // R10 monitor: a new pull may only begin while the clock line is low
   always @(posedge clk) begin
      if (rst_n && sda_pull && !prev_pull && scl_m) r10_bad++;
      prev_pull <= sda_pull;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_data(input int a);
      return (a <= int'(MAPL)) ? (a ^ 8'h5A) : 0;
   endfunction

   task automatic hq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
      end
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
      acked = ~sda_line;
      hq(); scl_m = 1'b0; hq();
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
         b[i] = sda_line;
         hq(); scl_m = 1'b0; hq();
      end
      sda_m = ~give_ack; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
      sda_m = 1'b1;
   endtask

   // write frame; returns index of first refused command byte, -1 if all accepted
   task automatic do_write(input string tag, input int n, input logic [7:0] b [4],
                           output int nack_at);
      logic a;
      nack_at = -1;
      bus_start();
      wr_byte({TGT, 1'b0}, a);
      chk({tag, " R1 address ack"}, int'(a), 1);
      for (int i = 0; i < n; i++) begin
         wr_byte(b[i], a);
         if (!a && nack_at < 0) nack_at = i;
      end
   endtask

   // read frame: count byte, then n data bytes, last one NACKed, then idle clocking
   task automatic read_block(input string tag, input int exp_cnt, input int n);
      logic a;
      logic [7:0] d;
      bus_start();
      wr_byte({TGT, 1'b1}, a);
      chk({tag, " R1 read address ack"}, int'(a), 1);
      rd_byte(1'b1, d);
      chk({tag, " count byte"}, int'(d), exp_cnt);
      for (int i = 0; i < n; i++) begin
         rd_byte(i < n - 1, d);
         chk({tag, " R5 data byte"}, int'(d), exp_data(exp_ptr));
         if (exp_ptr < 256) exp_ptr++;
      end
      rd_byte(1'b0, d);
      chk({tag, " R6 released after NACK"}, int'(d), 8'hFF);
      bus_stop();
   endtask

   task automatic t_reset();
      chk("R11 pull released", int'(sda_pull), 0);
      chk("R11 pointer", int'(reg_addr), 0);
      exp_ptr = 0;
      read_block("R11 first read", 1, 2);
   endtask

   task automatic t_generic();
      logic [7:0] b [4];
      int na;
      b = '{8'hF1, 8'h02, 8'h10, 8'h03};
      do_write("R2", 4, b, na);
      chk("R2 all command bytes acked", na, -1);
      exp_ptr = 'h10;
      read_block("R2 R5 past count", 3, 5);
   endtask

   task automatic t_persist();
      read_block("R7 resume", 3, 2);
      read_block("R7 resume again", 3, 1);
   endtask

   task automatic t_fixed();
      logic [7:0] b [4];
      int na;
      b = '{8'hF2, 8'h00, 8'h00, 8'h00};
      do_write("R3 F2", 1, b, na);
      chk("R3 F2 acked", na, -1);
      exp_ptr = 'h20;
      read_block("R3 F2", 6, 3);
      b[0] = 8'hFD;
      do_write("R3 FD", 1, b, na);
      chk("R3 FD acked", na, -1);
      exp_ptr = 'hF8;
      read_block("R3 R8 FD", 8, 2);
   endtask

   task automatic t_map_edge();
      logic [7:0] b [4];
      int na;
      b = '{8'hF1, 8'h02, 8'hBE, 8'h04};
      do_write("R8", 4, b, na);
      chk("R8 acked", na, -1);
      exp_ptr = 'hBE;
      read_block("R8 map edge", 4, 4);
   endtask

   task automatic t_saturate();
      logic [7:0] b [4];
      int na;
      b = '{8'hF1, 8'h02, 8'hFE, 8'h02};
      do_write("R9", 4, b, na);
      chk("R9 acked", na, -1);
      exp_ptr = 'hFE;
      read_block("R9 cross top", 2, 3);
      read_block("R9 no wrap", 2, 2);
   endtask

   task automatic t_invalid();
      logic [7:0] b [4];
      int na;
      b = '{8'hF0, 8'h00, 8'h00, 8'h00};
      do_write("R4 bad code", 1, b, na);
      chk("R4 bad code refused", na, 0);
      bus_stop();
      b = '{8'hF1, 8'h03, 8'h10, 8'h04};
      do_write("R4 bad length", 2, b, na);
      chk("R4 bad length refused", na, 1);
      bus_stop();
      b = '{8'hF1, 8'h02, 8'h10, 8'h00};
      do_write("R4 zero N", 4, b, na);
      chk("R4 zero N refused", na, 3);
      bus_stop();
      b = '{8'hF1, 8'h02, 8'h10, 8'h21};
      do_write("R4 large N", 4, b, na);
      chk("R4 large N refused", na, 3);
      bus_stop();
      b = '{8'hF3, 8'h55, 8'h00, 8'h00};
      do_write("R4 extra byte", 2, b, na);
      chk("R4 byte after command refused", na, 1);
      exp_ptr = 'h30;
      read_block("R4 state after extra byte", 4, 1);
      b = '{8'hF1, 8'h02, 8'h10, 8'h21};
      do_write("R4 reload check", 4, b, na);
      bus_stop();
      read_block("R4 unchanged state", 4, 1);
   endtask

   task automatic t_foreign();
      logic a;
      logic [7:0] d;
      bus_start();
      wr_byte({7'h2D, 1'b0}, a);
      chk("R1 foreign address not acked", int'(a), 0);
      rd_byte(1'b0, d);
      chk("R1 line untouched after foreign address", int'(d), 8'hFF);
      bus_stop();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      hq();
      t_reset();
      t_generic();
      t_persist();
      t_fixed();
      t_map_edge();
      t_saturate();
      t_invalid();
      t_foreign();
      chk("R10 pull began only with clock low", r10_bad, 0);
      finish_run();
   end

   initial begin
      repeat (190000) @(posedge clk);
      #1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end
endmodule